// File: doc/BRIEF.md
# Device Power Mode Transition Controller

This block holds the operating mode of a device and moves it from one mode to another. A mode changes on three kinds of events: a software request, a hardware failure event, or a system reset. Software writes a target mode code through a small write-only register port. The block checks that code against a fixed, asymmetric transition graph and against a mode-enable mask. It accepts only legal requests. The default run mode is the single gateway into the four user run modes and the test mode. The safe mode can be reached from every running mode, and it can only leave again towards the default run mode.

An accepted request raises a pending flag. The mode register moves to the target only when the resources-ready handshake answers, which stands in for the real regulator, clock and flash sequencing. A rejected request leaves the mode and the pending state untouched. It records each applicable cause in its own sticky bit. Two event flags, one for a finished transition and one for a rejected request, can each drive an interrupt. Software clears them by writing ones.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_n is low the outputs read mode 0 (reset), no pending transition, all cause bits and flags zero, and irq low. After rst_n rises, the mode stays 0 on every edge where res_ready is low. It becomes 1 (default run) on the first edge that samples res_ready high.
- R2: Mode codes on cur_mode and in request writes are 0 reset, 1 default run, 2 safe, 3 test, 4 to 7 run0 to run3, 8 halt, and 9 stop. Codes 10 to 15 are undefined.
- R3: A write to address 0 sets trans_pending at that edge when it is legal, the target is enabled and nothing is pending. The target is taken from wr_data[3:0]. cur_mode takes the target on the first later edge that samples res_ready high. At that edge trans_pending clears and done_flag sets.
- R4: Targets 3 (test) and 4 to 7 are accepted only from mode 1. From mode 3, software may go only to 1 or 2.
- R5: Target 2 (safe) is accepted from modes 1 and 3 to 9. From mode 2, the only accepted target is 1.
- R6: Targets 8 and 9 are accepted only from modes 4 to 7. From modes 8 and 9, software may go only to 1 or 2.
- R7: A request that the graph forbids sets fault_cause[0] and invalid_flag. This covers target 0, an undefined code, the current mode itself and any missing edge. cur_mode and trans_pending stay unchanged.
- R8: A write to address 1 loads the enable mask from wr_data[9:0], one bit per mode code. The bits for modes 0, 1 and 2 always read back as enabled. A request for a disabled mode sets fault_cause[1] and invalid_flag and is not applied. The mask resets to all enabled.
- R9: A request written while trans_pending is high sets fault_cause[2] and invalid_flag. It does not change the pending target.
- R10: A hw_fail sampled high in modes 1 or 3 to 9 moves cur_mode to 2 at that edge. It clears trans_pending and sets done_flag. A request written on the same edge is dropped with no cause recorded. In modes 0 and 2, hw_fail has no effect.
- R11: A write to address 3 clears the flags whose wr_data bit is one: bit 0 done_flag, bit 1 invalid_flag, bits 4:2 fault_cause[2:0]. A set on the same edge wins over the clear. A write to address 2 sets the interrupt enables: bit 0 for done, bit 1 for invalid. irq is the OR of each enabled flag.
- R12: Taking rst_n low returns cur_mode to 0 at once, from any mode, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 request, 1 enable mask, 2 irq enables, 3 flag clear |
| wr_data | input | 16 | Write data |
| hw_fail | input | 1 | Hardware failure event |
| res_ready | input | 1 | Resources-ready acknowledge |
| cur_mode | output | 4 | Current mode code |
| trans_pending | output | 1 | Accepted transition waiting for resources |
| fault_cause | output | 3 | Sticky causes: [0] forbidden, [1] disabled, [2] busy |
| done_flag | output | 1 | Transition-complete flag |
| invalid_flag | output | 1 | Rejected-request flag |
| irq | output | 1 | Interrupt request |

## Verification
Every output is a register, or irq, which is a plain OR of registers. Each input sampled at one edge therefore shows on the outputs after that same edge. An accepted request appears as trans_pending one edge after the write. The new mode appears one edge after res_ready is first sampled high with the request pending. The bench drives inputs at the falling edge and mirrors each rising edge in its reference model. It compares all outputs at the next falling edge, so every result is checked in the cycle it is due. Reset is checked a fraction of a nanosecond after rst_n falls, with no clock edge in between.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int MODE_W    = 4;
  localparam int NUM_MODES = 10;
  localparam int CAUSE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    M_RESET = 4'd0,
    M_DRUN  = 4'd1,
    M_SAFE  = 4'd2,
    M_TEST  = 4'd3,
    M_RUN0  = 4'd4,
    M_RUN1  = 4'd5,
    M_RUN2  = 4'd6,
    M_RUN3  = 4'd7,
    M_HALT  = 4'd8,
    M_STOP  = 4'd9
  } mode_e;

  // register addresses
  localparam logic [1:0] A_REQ   = 2'd0;
  localparam logic [1:0] A_EN    = 2'd1;
  localparam logic [1:0] A_IRQEN = 2'd2;
  localparam logic [1:0] A_CLR   = 2'd3;

  // modes that can never be masked
  localparam logic [NUM_MODES-1:0] LOCKED_EN = NUM_MODES'(3'b111);

  function automatic logic is_run_user(input logic [MODE_W-1:0] m);
    return (m >= M_RUN0) && (m <= M_RUN3);
  endfunction

  // modes in which a hardware failure forces the safe mode
  function automatic logic is_active(input logic [MODE_W-1:0] m);
    return (m != M_RESET) && (m != M_SAFE) && (m < MODE_W'(NUM_MODES));
  endfunction

  function automatic logic legal_move(input logic [MODE_W-1:0] cur,
                                      input logic [MODE_W-1:0] tgt);
    logic ok;
    ok = 1'b0;
    case (cur)
      M_DRUN:  ok = (tgt == M_SAFE) || (tgt == M_TEST) || is_run_user(tgt);
      M_SAFE:  ok = (tgt == M_DRUN);
      M_TEST:  ok = (tgt == M_DRUN) || (tgt == M_SAFE);
      M_RUN0, M_RUN1, M_RUN2, M_RUN3:
               ok = (tgt == M_DRUN) || (tgt == M_SAFE) ||
                    (tgt == M_HALT) || (tgt == M_STOP);
      M_HALT, M_STOP:
               ok = (tgt == M_DRUN) || (tgt == M_SAFE);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pwr_mode_cfg.sv
module pwr_mode_cfg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_MODES-1:0] mode_en,
  output logic [1:0]           irq_en
);

  logic en_wr, irq_wr;
  assign en_wr  = wr_en && (wr_addr == ADDR_W'(A_EN));
  assign irq_wr = wr_en && (wr_addr == ADDR_W'(A_IRQEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en <= '1;
      irq_en  <= '0;
    end else begin
      if (en_wr)  mode_en <= wr_data[NUM_MODES-1:0] | LOCKED_EN;
      if (irq_wr) irq_en  <= wr_data[1:0];
    end
  end

endmodule

// File: rtl/pwr_mode_check.sv
module pwr_mode_check
  import pwr_mode_pkg::*;
(
  input  logic                 req_wr,
  input  logic                 hw_take,
  input  logic                 pending,
  input  logic [MODE_W-1:0]    cur,
  input  logic [MODE_W-1:0]    tgt,
  input  logic [NUM_MODES-1:0] mode_en,
  output logic                 accept,
  output logic                 reject,
  output logic [CAUSE_W-1:0]   cause_set
);

  logic             tgt_on;
  logic             live_wr;
  logic [CAUSE_W-1:0] cause;

  always_comb begin
    tgt_on = 1'b1;
    if (tgt < MODE_W'(NUM_MODES)) tgt_on = mode_en[tgt];
  end

  assign cause[0] = !legal_move(cur, tgt);
  assign cause[1] = !tgt_on;
  assign cause[2] = pending;

  // a hardware failure on the same edge swallows the request
  assign live_wr   = req_wr && !hw_take;
  assign accept    = live_wr && (cause == '0);
  assign reject    = live_wr && (cause != '0);
  assign cause_set = live_wr ? cause : '0;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_ready,
  input  logic              hw_take,
  input  logic              accept,
  input  logic [MODE_W-1:0] req_tgt,
  output logic [MODE_W-1:0] cur_q,
  output logic              pend_q,
  output logic              done_evt
);

  logic [MODE_W-1:0] tgt_q;
  logic              finish;

  assign finish   = pend_q && res_ready && (cur_q != M_RESET);
  assign done_evt = hw_take || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= M_RESET;
      pend_q <= 1'b0;
      tgt_q  <= M_DRUN;
    end else if (cur_q == M_RESET) begin
      if (res_ready) cur_q <= M_DRUN;
    end else if (hw_take) begin
      cur_q  <= M_SAFE;
      pend_q <= 1'b0;
    end else if (finish) begin
      cur_q  <= tgt_q;
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      tgt_q  <= req_tgt;
    end
  end

endmodule

// File: rtl/pwr_mode_status.sv
module pwr_mode_status
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               done_evt,
  input  logic               reject,
  input  logic [CAUSE_W-1:0] cause_set,
  input  logic [1:0]         irq_en,
  output logic               done_q,
  output logic               inv_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               irq
);

  localparam int CLR_W = 2 + CAUSE_W;

  logic [CLR_W-1:0] clr;
  assign clr = (wr_en && (wr_addr == ADDR_W'(A_CLR))) ? wr_data[CLR_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      done_q  <= (done_q & ~clr[0]) | done_evt;
      inv_q   <= (inv_q & ~clr[1]) | reject;
      cause_q <= (cause_q & ~clr[CLR_W-1:2]) | cause_set;
    end
  end

  assign irq = (done_q && irq_en[0]) || (inv_q && irq_en[1]);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hw_fail,
  input  logic               res_ready,
  output logic [MODE_W-1:0]  cur_mode,
  output logic               trans_pending,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic               done_flag,
  output logic               invalid_flag,
  output logic               irq
);

  // named internal events, observed by the checker
  logic                 req_wr;
  logic                 hw_take;
  logic                 req_accept;
  logic                 req_reject;
  logic                 done_evt;
  logic [CAUSE_W-1:0]   cause_set;
  logic [NUM_MODES-1:0] mode_en;
  logic [1:0]           irq_en;
  logic [MODE_W-1:0]    req_tgt;

  assign req_wr  = wr_en && (wr_addr == ADDR_W'(A_REQ));
  assign req_tgt = wr_data[MODE_W-1:0];
  assign hw_take = hw_fail && is_active(cur_mode);

  pwr_mode_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_en (mode_en),
    .irq_en  (irq_en)
  );

  pwr_mode_check u_check (
    .req_wr    (req_wr),
    .hw_take   (hw_take),
    .pending   (trans_pending),
    .cur       (cur_mode),
    .tgt       (req_tgt),
    .mode_en   (mode_en),
    .accept    (req_accept),
    .reject    (req_reject),
    .cause_set (cause_set)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_ready (res_ready),
    .hw_take   (hw_take),
    .accept    (req_accept),
    .req_tgt   (req_tgt),
    .cur_q     (cur_mode),
    .pend_q    (trans_pending),
    .done_evt  (done_evt)
  );

  pwr_mode_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done_evt  (done_evt),
    .reject    (req_reject),
    .cause_set (cause_set),
    .irq_en    (irq_en),
    .done_q    (done_flag),
    .inv_q     (invalid_flag),
    .cause_q   (fault_cause),
    .irq       (irq)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  cur_mode,
  input logic               trans_pending,
  input logic [CAUSE_W-1:0] fault_cause,
  input logic               res_ready,
  input logic               req_wr,
  input logic               req_accept,
  input logic               req_reject,
  input logic               hw_take
);

  // R3: an accepted request is pending on the next cycle
  p_accept_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> trans_pending);

  // R3: outside reset the mode moves only on completion or failure
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != M_RESET && !(trans_pending && res_ready) && !hw_take)
      |=> $stable(cur_mode));

  // R4: test mode is entered only from the default run mode
  p_test_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != M_TEST && cur_mode != M_DRUN) |=> (cur_mode != M_TEST));

  // R4: user run modes are entered only from the default run mode
  p_run_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != M_DRUN && !is_run_user(cur_mode)) |=> !is_run_user(cur_mode));

  // R5: safe mode leaves only towards the default run mode
  p_safe_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_SAFE) |=> (cur_mode == M_SAFE || cur_mode == M_DRUN));

  // R7: a rejected request leaves an idle controller idle
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_reject && !trans_pending && cur_mode != M_RESET)
      |=> (!trans_pending && $stable(cur_mode)));

  // R9: a request during a pending transition flags busy
  p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && trans_pending && !hw_take) |=> fault_cause[2]);

  // R10: a hardware failure lands in safe mode with nothing pending
  p_fail_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> (cur_mode == M_SAFE && !trans_pending));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cur_mode      (cur_mode),
  .trans_pending (trans_pending),
  .fault_cause   (fault_cause),
  .res_ready     (res_ready),
  .req_wr        (req_wr),
  .req_accept    (req_accept),
  .req_reject    (req_reject),
  .hw_take       (hw_take)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;

  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        hw_fail = 1'b0;
  logic        res_ready = 1'b0;
  logic [3:0]  cur_mode;
  logic        trans_pending;
  logic [2:0]  fault_cause;
  logic        done_flag;
  logic        invalid_flag;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hw_fail(hw_fail), .res_ready(res_ready),
    .cur_mode(cur_mode), .trans_pending(trans_pending),
    .fault_cause(fault_cause), .done_flag(done_flag),
    .invalid_flag(invalid_flag), .irq(irq)
  );

  // reference model state
  logic [3:0] m_cur, m_tgt;
  logic       m_pend, m_done, m_inv;
  logic [2:0] m_cause;
  logic [9:0] m_en;
  logic [1:0] m_ien;

  // allowed software moves, organised by target
  function automatic bit may_go(input logic [3:0] from, input logic [3:0] to);
    case (to)
      4'd1:                   return (from >= 4'd2 && from <= 4'd9);
      4'd2:                   return (from == 4'd1) || (from >= 4'd3 && from <= 4'd9);
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return (from == 4'd1);
      4'd8, 4'd9:             return (from >= 4'd4 && from <= 4'd7);
      default:                return 1'b0;
    endcase
  endfunction

  function automatic bit fail_hits(input logic [3:0] m);
    return (m == 4'd1) || (m >= 4'd3 && m <= 4'd9);
  endfunction

  task automatic model_reset();
    m_cur = 4'd0; m_tgt = 4'd1; m_pend = 0; m_done = 0; m_inv = 0;
    m_cause = 3'd0; m_en = 10'h3FF; m_ien = 2'd0;
  endtask

  task automatic model_edge();
    bit         hwk, fin, rq, bad;
    logic [2:0] c;
    logic [4:0] clr;
    if (!rst_n) begin model_reset(); return; end
    hwk = hw_fail && fail_hits(m_cur);
    fin = m_pend && res_ready && (m_cur != 4'd0);
    rq  = wr_en && (wr_addr == 2'd0) && !hwk;
    c = 3'd0;
    if (rq) begin
      c[0] = !may_go(m_cur, wr_data[3:0]);
      c[1] = (wr_data[3:0] <= 4'd9) && !m_en[wr_data[3:0]];
      c[2] = m_pend;
    end
    bad = (c != 3'd0);
    clr = (wr_en && wr_addr == 2'd3) ? wr_data[4:0] : 5'd0;
    m_done  = (m_done && !clr[0]) || hwk || fin;
    m_inv   = (m_inv && !clr[1]) || bad;
    m_cause = (m_cause & ~clr[4:2]) | c;
    if (m_cur == 4'd0) begin
      if (res_ready) m_cur = 4'd1;
    end else if (hwk) begin
      m_cur = 4'd2; m_pend = 0;
    end else if (fin) begin
      m_cur = m_tgt; m_pend = 0;
    end else if (rq && !bad) begin
      m_pend = 1; m_tgt = wr_data[3:0];
    end
    if (wr_en && wr_addr == 2'd1) m_en = wr_data[9:0] | 10'b0000000111;
    if (wr_en && wr_addr == 2'd2) m_ien = wr_data[1:0];
  endtask

  task automatic compare(input string req);
    logic [10:0] got, exp;
    logic        eirq;
    eirq = (m_done && m_ien[0]) || (m_inv && m_ien[1]);
    got = {cur_mode, trans_pending, fault_cause, done_flag, invalid_flag, irq};
    exp = {m_cur, m_pend, m_cause, m_done, m_inv, eirq};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (mode/pend/cause/done/inv/irq)", req, got, exp);
    end
  endtask

  task automatic check_mode(input string req, input logic [3:0] want);
    checks++;
    if (cur_mode !== want) begin
      fails++;
      $display("FAIL %s: mode got %0d expected %0d", req, cur_mode, want);
    end
  endtask

  task automatic drive(input bit we, input logic [1:0] a, input logic [15:0] d,
                       input bit hf, input bit rr);
    wr_en = we; wr_addr = a; wr_data = d; hw_fail = hf; res_ready = rr;
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input bit rr, input string req);
    drive(0, 2'd0, 16'd0, 0, rr);
    step(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    compare("R1 in reset");
    step("R1 reset held");
    rst_n = 1'b1;
    idle(0, "R1 wait ready");
    idle(0, "R1 wait ready");
    idle(1, "R1 enter default run");
    check_mode("R1/R2 default run code", 4'd1);

    // R3 / R9: request run2, busy request while pending, completion
    drive(1, 2'd0, 16'd6, 0, 0); step("R3 accept run2");
    drive(1, 2'd0, 16'd3, 0, 0); step("R9 busy while pending");
    idle(0, "R3 hold without ready");
    idle(1, "R3 complete");
    check_mode("R3 run2 reached", 4'd6);
    // R4: test from a run mode is forbidden
    drive(1, 2'd0, 16'd3, 0, 1); step("R4 test from run2");
    drive(1, 2'd3, 16'h001F, 0, 0); step("R11 clear all");
    // R6: halt from run2, then halt to run0 forbidden
    drive(1, 2'd0, 16'd8, 0, 0); step("R6 accept halt");
    idle(1, "R6 reach halt");
    drive(1, 2'd0, 16'd4, 0, 0); step("R6 halt to run0");
    // R7: undefined code and self target
    drive(1, 2'd0, 16'd12, 0, 0); step("R7 undefined code");
    drive(1, 2'd0, 16'd8, 0, 0); step("R7 self target");
    // R10: failure in halt, simultaneous request dropped
    drive(1, 2'd3, 16'h001F, 0, 0); step("R11 clear");
    drive(1, 2'd0, 16'd1, 1, 0); step("R10 fail to safe");
    check_mode("R10 safe code", 4'd2);
    drive(0, 2'd0, 16'd0, 1, 0); step("R10 fail in safe ignored");
    // R5: safe exits
    drive(1, 2'd0, 16'd5, 0, 0); step("R5 safe to run1 forbidden");
    drive(1, 2'd0, 16'd1, 0, 0); step("R5 safe to default run");
    idle(1, "R5 reach default run");
    // R8: mask everything, locked modes stay reachable
    drive(1, 2'd1, 16'h0000, 0, 0); step("R8 mask write");
    drive(1, 2'd0, 16'd4, 0, 0); step("R8 masked run0");
    drive(1, 2'd0, 16'd2, 0, 0); step("R8 safe not maskable");
    idle(1, "R8 reach safe");
    drive(1, 2'd1, 16'h03FF, 0, 0); step("R8 unmask");
    // R11: interrupt enables and set-wins
    drive(1, 2'd2, 16'd2, 0, 0); step("R11 enable invalid irq");
    drive(1, 2'd3, 16'h0002, 0, 0); step("R11 clear invalid");
    drive(1, 2'd2, 16'd3, 0, 0); step("R11 enable both");
    drive(1, 2'd3, 16'h001F, 0, 0); step("R11 clear all");
    drive(1, 2'd0, 16'd7, 0, 0); step("R11 invalid irq");

    // R12: asynchronous return to reset from safe
    @(negedge clk);
    drive(0, 2'd0, 16'd0, 0, 0);
    #1 rst_n = 1'b0;
    #0.5;
    model_reset();
    compare("R12 async reset");
    check_mode("R12 reset code", 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1, "R1 re-enter default run");

    // constrained random phase, R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] d;
      sel = $urandom_range(99);
      d = 16'($urandom);
      if (sel < 60)      drive(1, 2'd0, 16'($urandom_range(11)), 0, 1'($urandom));
      else if (sel < 65) drive(1, 2'd1, d, 0, 1'($urandom));
      else if (sel < 70) drive(1, 2'd2, d, 0, 1'($urandom));
      else if (sel < 80) drive(1, 2'd3, d, 0, 1'($urandom));
      else               drive(0, 2'd0, 16'd0, ($urandom_range(19) == 0), 1'($urandom));
      step("R3-R11 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule